// File: doc/BRIEF.md
# Dual-Port Instruction Queue

This block is a small circular instruction buffer that sits between an instruction fetch stage and a dispatch stage. In any cycle it can take in none, one or two instructions from fetch and hand none, one or two instructions to dispatch. Both happen in the same cycle. The two oldest queued instructions are always visible on the two read slots, in program order. Dispatch returns a count of how many of them it took.

The queue reports its free entries every cycle, so fetch can offer only what fits. Any offer that is larger than the free space is trimmed: the older instruction is kept and the surplus is dropped. When dispatch frees entries, that space can be written from the next cycle on. A misprediction flush discards every queued instruction in one cycle. Flush overrides any write or dispatch in the same cycle.

Top module: `dual_issue_iq`

## Requirements
- R1: While reset is asserted, and directly after it, the queue is empty: both read-valid bits are 0 and the free count equals the depth (6).
- R2: Read slot 0 carries the oldest queued instruction and read slot 1 the next one. `rd_vld[0]` is set when at least one entry is held, and `rd_vld[1]` when at least two are held.
- R3: The valid write slots are appended in slot order, slot 0 before slot 1. When only `wr_vld[1]` is set, that instruction alone is appended.
- R4: A cycle's writes are limited to the free count at the start of that cycle. The surplus is discarded, with the slot-1 instruction dropped before the slot-0 one. Entries freed by dispatch can be written from the following cycle on.
- R5: `rd_accept` is a binary count in which a value of 3 means 2. It removes the oldest min(count, held entries) instructions, so an accept that exceeds the held entries removes only those entries.
- R6: `free_cnt` always equals 6 minus the number of held instructions, and it stays within 0 to 6.
- R7: With `flush` high at a clock edge, the queue is empty after that edge, whatever the write and accept inputs were.
- R8: Writes and dispatches in the same cycle both take effect, and the order among the survivors is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all queued instructions |
| wr_vld | input | 2 | Valid bits of the two fetch write slots |
| wr_data0 | input | 32 | Write slot 0 instruction (older) |
| wr_data1 | input | 32 | Write slot 1 instruction (younger) |
| rd_accept | input | 2 | Number of read slots taken by dispatch this cycle |
| rd_vld | output | 2 | Valid bits of the two read slots |
| rd_data0 | output | 32 | Oldest queued instruction |
| rd_data1 | output | 32 | Second oldest queued instruction |
| free_cnt | output | 3 | Number of free entries |

## Verification
The main sequence offers dual, single-slot-0 and single-slot-1 writes against dispatch counts of 0, 1, 2 and 3. It runs from empty through full and wraps around the ring. Each write carries a unique tag, so a lost, duplicated or reordered entry shows up on the read slots. Offers into a full queue and into one free entry check the trimming of R4, and accepts on an empty or one-entry queue check the clamping of R5. A flush issued together with a dual write and a dispatch must leave nothing behind. A reset asserted mid-run must clear the queue without waiting for a clock edge.

// File: rtl/iq_pkg.sv
package iq_pkg;

  localparam int unsigned IQ_DEPTH_DEF = 6;
  localparam int unsigned IQ_WIDTH_DEF = 32;

  // Per-cycle transfer count: 0, 1 or 2 instructions.
  typedef logic [1:0] xfer_cnt_t;

  // Modular pointer advance for a ring whose size need not be a power of two.
  function automatic int unsigned iq_wrap(input int unsigned ptr,
                                          input int unsigned inc,
                                          input int unsigned depth);
    int unsigned sum;
    sum = ptr + inc;
    if (sum >= depth) sum = sum - depth;
    return sum;
  endfunction

endpackage

// File: rtl/iq_slot_select.sv
module iq_slot_select
  import iq_pkg::*;
#(
  parameter int unsigned WIDTH = IQ_WIDTH_DEF,
  parameter int unsigned CNT_W = 3
) (
  input  logic             flush,
  input  logic [1:0]       wr_vld,
  input  logic [WIDTH-1:0] wr_data0,
  input  logic [WIDTH-1:0] wr_data1,
  input  logic [CNT_W-1:0] free_cnt,
  output xfer_cnt_t        n_wr,
  output logic [WIDTH-1:0] cmp_data0,
  output logic [WIDTH-1:0] cmp_data1
);

  xfer_cnt_t req;

  // Compact the valid slots so the older valid one is always first.
  always_comb begin
    req       = {1'b0, wr_vld[0]} + {1'b0, wr_vld[1]};
    cmp_data0 = wr_vld[0] ? wr_data0 : wr_data1;
    cmp_data1 = wr_data1;
  end

  // Trim the offer to the free space seen at the start of the cycle.
  always_comb begin
    if (flush) begin
      n_wr = 2'd0;
    end else if (free_cnt >= CNT_W'(2)) begin
      n_wr = req;
    end else if (free_cnt == CNT_W'(1)) begin
      n_wr = (req != 2'd0) ? 2'd1 : 2'd0;
    end else begin
      n_wr = 2'd0;
    end
  end

  always_comb begin
    assert (n_wr <= req) else $error("AST_WR_TRIM_LE_REQ"); // R4
  end

endmodule

// File: rtl/iq_ptr_ctrl.sv
module iq_ptr_ctrl
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH = IQ_DEPTH_DEF,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  xfer_cnt_t        n_wr,
  input  logic [1:0]       rd_accept,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] free_cnt,
  output xfer_cnt_t        n_rd
);

  logic [PTR_W-1:0] head_n;
  logic [PTR_W-1:0] tail_n;
  logic [CNT_W-1:0] count_n;
  logic             upd_en;
  xfer_cnt_t        acc_clamped;

  assign free_cnt = CNT_W'(DEPTH) - count;

  // Dispatch count: a request of 3 means 2, then limited to the entries held.
  always_comb begin
    acc_clamped = (rd_accept == 2'd3) ? 2'd2 : rd_accept;
    if (flush) begin
      n_rd = 2'd0;
    end else if (count >= CNT_W'(2)) begin
      n_rd = acc_clamped;
    end else if (count == CNT_W'(1)) begin
      n_rd = (acc_clamped != 2'd0) ? 2'd1 : 2'd0;
    end else begin
      n_rd = 2'd0;
    end
  end

  // Next-state logic.
  always_comb begin
    upd_en  = flush || (n_wr != 2'd0) || (n_rd != 2'd0);
    head_n  = head;
    tail_n  = tail;
    count_n = count;
    if (flush) begin
      head_n  = '0;
      tail_n  = '0;
      count_n = '0;
    end else begin
      head_n  = PTR_W'(iq_wrap(int'(head), int'(n_rd), DEPTH));
      tail_n  = PTR_W'(iq_wrap(int'(tail), int'(n_wr), DEPTH));
      count_n = count + CNT_W'(n_wr) - CNT_W'(n_rd);
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (upd_en) begin
      head  <= head_n;
      tail  <= tail_n;
      count <= count_n;
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && count == CNT_W'(DEPTH) && rd_accept == 2'd0) |=> $stable(count)); // R4

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && count == '0 && n_wr == 2'd0) |=> (count == '0)); // R5

  AST_HEAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(head) < DEPTH) && (int'(tail) < DEPTH)); // R6

endmodule

// File: rtl/iq_store.sv
module iq_store
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH = IQ_DEPTH_DEF,
  parameter int unsigned WIDTH = IQ_WIDTH_DEF,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] tail,
  input  xfer_cnt_t        n_wr,
  input  logic [WIDTH-1:0] cmp_data0,
  input  logic [WIDTH-1:0] cmp_data1,
  output logic [WIDTH-1:0] rd_data0,
  output logic [WIDTH-1:0] rd_data1
);

  logic [DEPTH-1:0][WIDTH-1:0] ent_q;
  logic [PTR_W-1:0]            tail_p1;
  logic [PTR_W-1:0]            head_p1;

  assign tail_p1 = PTR_W'(iq_wrap(int'(tail), 1, DEPTH));
  assign head_p1 = PTR_W'(iq_wrap(int'(head), 1, DEPTH));

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic             we_first;
    logic             we_second;
    logic             ent_en;
    logic [WIDTH-1:0] ent_d;
    logic [WIDTH-1:0] ent_r;

    always_comb begin
      we_first  = (tail == PTR_W'(i)) && (n_wr != 2'd0);
      we_second = (tail_p1 == PTR_W'(i)) && (n_wr == 2'd2);
      ent_en    = we_first || we_second;
      ent_d     = we_first ? cmp_data0 : cmp_data1;
    end

    // Data storage carries no reset; validity comes from the pointer state.
    always_ff @(posedge clk) begin
      if (ent_en) ent_r <= ent_d;
    end

    assign ent_q[i] = ent_r;

    always_comb begin
      assert (!(we_first && we_second)) else $error("AST_SINGLE_WRITER"); // R3
    end
  end

  assign rd_data0 = ent_q[head];
  assign rd_data1 = ent_q[head_p1];

endmodule

// File: rtl/dual_issue_iq.sv
module dual_issue_iq
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH = IQ_DEPTH_DEF,
  parameter int unsigned WIDTH = IQ_WIDTH_DEF,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [1:0]       wr_vld,
  input  logic [WIDTH-1:0] wr_data0,
  input  logic [WIDTH-1:0] wr_data1,
  input  logic [1:0]       rd_accept,
  output logic [1:0]       rd_vld,
  output logic [WIDTH-1:0] rd_data0,
  output logic [WIDTH-1:0] rd_data1,
  output logic [CNT_W-1:0] free_cnt
);

  logic [PTR_W-1:0] head;
  logic [PTR_W-1:0] tail;
  logic [CNT_W-1:0] count;
  xfer_cnt_t        n_wr;
  xfer_cnt_t        n_rd;
  logic [WIDTH-1:0] cmp_data0;
  logic [WIDTH-1:0] cmp_data1;

  iq_slot_select #(
    .WIDTH (WIDTH),
    .CNT_W (CNT_W)
  ) u_sel (
    .flush     (flush),
    .wr_vld    (wr_vld),
    .wr_data0  (wr_data0),
    .wr_data1  (wr_data1),
    .free_cnt  (free_cnt),
    .n_wr      (n_wr),
    .cmp_data0 (cmp_data0),
    .cmp_data1 (cmp_data1)
  );

  iq_ptr_ctrl #(
    .DEPTH (DEPTH)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .n_wr      (n_wr),
    .rd_accept (rd_accept),
    .head      (head),
    .tail      (tail),
    .count     (count),
    .free_cnt  (free_cnt),
    .n_rd      (n_rd)
  );

  iq_store #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
  ) u_store (
    .clk       (clk),
    .head      (head),
    .tail      (tail),
    .n_wr      (n_wr),
    .cmp_data0 (cmp_data0),
    .cmp_data1 (cmp_data1),
    .rd_data0  (rd_data0),
    .rd_data1  (rd_data1)
  );

  assign rd_vld[0] = (count != '0);
  assign rd_vld[1] = (count >= CNT_W'(2));

  AST_RDVLD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld[1] |-> rd_vld[0]); // R2

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && free_cnt == '0 && rd_accept == 2'd0) |=> (free_cnt == '0)); // R4

  AST_SLOT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && n_rd == 2'd1 && $past(1'b1) && rd_vld[1] && wr_vld == 2'b00) |=>
      (rd_data0 == $past(rd_data1))); // R8

endmodule

// File: tb/dual_issue_iq_tb.sv
module dual_issue_iq_tb_top;

  localparam int unsigned DEPTH   = 6;
  localparam int unsigned WIDTH   = 32;
  localparam time         CLK_PER = 10ns;
  localparam int          NSTEPS  = 17;

  // Vector: {flush, wr_vld[1:0], rd_accept[1:0], expected occupancy after[2:0]}
  localparam logic [7:0] VEC [NSTEPS] = '{
    8'b0_11_00_010,  // fill
    8'b0_11_00_100,
    8'b0_11_00_110,  // full
    8'b0_11_10_100,  // full: writes dropped, two dispatched
    8'b0_00_10_010,
    8'b0_11_01_011,  // concurrent write/read
    8'b0_11_00_101,
    8'b0_11_10_100,  // one free: only slot 0 taken
    8'b0_01_01_100,
    8'b0_10_00_101,  // slot 1 alone
    8'b1_11_10_000,  // flush beats write and read
    8'b0_00_10_000,  // accept on empty
    8'b0_01_10_001,  // write to empty with accept
    8'b0_00_10_000,  // accept 2 with one held
    8'b0_11_11_010,  // accept 3 on empty
    8'b0_00_11_000,  // accept 3 treated as 2
    8'b0_11_01_010
  };

  logic             clk;
  logic             rst_n;
  logic             flush;
  logic [1:0]       wr_vld;
  logic [WIDTH-1:0] wr_data0;
  logic [WIDTH-1:0] wr_data1;
  logic [1:0]       rd_accept;
  logic [1:0]       rd_vld;
  logic [WIDTH-1:0] rd_data0;
  logic [WIDTH-1:0] rd_data1;
  logic [2:0]       free_cnt;

  int checks;
  int failures;
  bit done;
  logic [WIDTH-1:0] mq[$];
  logic [WIDTH-1:0] next_id;
  string tags [NSTEPS];

  dual_issue_iq #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wr_vld    (wr_vld),
    .wr_data0  (wr_data0),
    .wr_data1  (wr_data1),
    .rd_accept (rd_accept),
    .rd_vld    (rd_vld),
    .rd_data0  (rd_data0),
    .rd_data1  (rd_data1),
    .free_cnt  (free_cnt)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PER / 2) clk = ~clk;
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare outputs against the bench model of the queue.
  task automatic check_model(input string tag);
    logic [1:0] ev;
    ev = {mq.size() >= 2, mq.size() >= 1};
    chk(tag, "rd_vld", 64'(rd_vld), 64'(ev));
    if (mq.size() >= 1) chk({tag, " R2"}, "rd_data0", 64'(rd_data0), 64'(mq[0]));
    if (mq.size() >= 2) chk({tag, " R2"}, "rd_data1", 64'(rd_data1), 64'(mq[1]));
  endtask

  // Apply one cycle of stimulus and advance the model from the pre-edge state.
  task automatic step(input logic f, input logic [1:0] wv, input logic [1:0] acc);
    int nr;
    int nw;
    int fr;
    logic [WIDTH-1:0] offer[$];
    flush     = f;
    wr_vld    = wv;
    rd_accept = acc;
    wr_data0  = next_id;
    wr_data1  = next_id + 1;
    next_id   = next_id + 2;
    if (wv[0]) offer.push_back(wr_data0);
    if (wv[1]) offer.push_back(wr_data1);
    if (f) begin
      mq.delete();
    end else begin
      fr = DEPTH - mq.size();
      nr = (acc == 2'd3) ? 2 : int'(acc);
      if (nr > mq.size()) nr = mq.size();
      nw = offer.size();
      if (nw > fr) nw = fr;
      for (int k = 0; k < nr; k++) void'(mq.pop_front());
      for (int k = 0; k < nw; k++) mq.push_back(offer[k]);
    end
    @(posedge clk);
    @(negedge clk);
    flush     = 1'b0;
    wr_vld    = 2'b00;
    rd_accept = 2'b00;
  endtask

  initial begin
    tags = '{"R3 R6", "R3 R6", "R3 R6", "R4", "R5", "R8", "R3", "R4",
             "R8", "R3", "R7", "R5", "R5", "R5", "R5", "R5", "R8"};
    checks    = 0;
    failures  = 0;
    done      = 1'b0;
    next_id   = 32'hA000_0000;
    flush     = 1'b0;
    wr_vld    = 2'b00;
    rd_accept = 2'b00;
    wr_data0  = '0;
    wr_data1  = '0;
    rst_n     = 1'b0;
    #(CLK_PER * 2.5);
    // R1: reset state
    chk("R1", "rd_vld in reset", 64'(rd_vld), 64'(0));
    chk("R1", "free_cnt in reset", 64'(free_cnt), 64'(DEPTH));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rd_vld after reset", 64'(rd_vld), 64'(0));
    chk("R1", "free_cnt after reset", 64'(free_cnt), 64'(DEPTH));

    for (int s = 0; s < NSTEPS; s++) begin
      step(VEC[s][7], VEC[s][6:5], VEC[s][4:3]);
      chk({tags[s], " R6"}, $sformatf("free_cnt step %0d", s),
          64'(free_cnt), 64'(DEPTH - int'(VEC[s][2:0])));
      check_model(tags[s]);
    end

    // R4: space freed by dispatch is not writable in the same cycle
    step(1'b0, 2'b11, 2'b00);
    step(1'b0, 2'b11, 2'b00);   // now 6 held
    chk("R4", "full before", 64'(free_cnt), 64'(0));
    step(1'b0, 2'b01, 2'b01);   // read one, write dropped
    chk("R4", "freed space not reused same cycle", 64'(free_cnt), 64'(1));
    check_model("R4");

    // R1: asynchronous reset mid-run clears without a clock edge
    #(CLK_PER / 4);
    rst_n = 1'b0;
    #1;
    chk("R1", "free_cnt async reset", 64'(free_cnt), 64'(DEPTH));
    chk("R1", "rd_vld async reset", 64'(rd_vld), 64'(0));
    mq.delete();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 2'b10, 2'b00);   // R3: single slot-1 write into empty queue
    chk("R3", "free_cnt single slot1", 64'(free_cnt), 64'(DEPTH - 1));
    check_model("R3");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule